// File: doc/BRIEF.md
# Interrupt Poll and Dispatch Sequencer

This block decides, cycle by cycle, when an 8-bit processor core leaves its instruction stream to enter an interrupt. It watches a level-sensitive maskable request line and an edge-triggered non-maskable request line. At every instruction boundary that the core's sequencer reports, it either lets the next opcode fetch proceed or starts a seven-cycle entry sequence. During that sequence it presents the chosen vector and the return tag, which is the identifier of the instruction that would have run next.

The block also reproduces a timing quirk of the older process generation. A branch that is taken without leaving its page ends in a cycle where no poll is made. A request that becomes serviceable at that boundary therefore waits until one more complete instruction has run. Branches that are not taken, and taken branches that cross a page, dispatch at their boundary like any other instruction. Opcode decode, the data path and the bus are outside the block. The core supplies the last-cycle strobe, the branch kind, the mask flag, the next-instruction tag and a clock enable.

Top module: `irq_dispatch_seq`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every stored request and the entry state. After reset, seq_busy=0, seq_cnt=0, vec_nmi=0, ret_tag=0 and take_int=0, and a request that was pending before the reset is never dispatched.
- R2: The non-maskable line becomes serviceable only after a high-to-low transition followed by low samples at the end of two consecutive enabled cycles. Serviceability counts from the end of the second such cycle. A single low cycle is never serviced.
- R3: When a request is serviceable at the end of an instruction's final cycle (insn_last=1, ce=1), take_int is 1 in that same cycle. With br_kind=2'b00 (not a branch), the entry sequence starts with the next enabled edge.
- R4: The entry sequence lasts exactly 7 enabled cycles. seq_busy is 1 and seq_cnt steps 0,1,…,6, then seq_busy returns to 0. take_int is never 1 while seq_busy=1.
- R5: At a boundary with br_kind=2'b10 (taken branch, same page) no dispatch happens. A request that is still serviceable is dispatched at the end of the next instruction. This applies to both request lines.
- R6: Boundaries with br_kind=2'b01 (branch not taken) or br_kind=2'b11 (taken branch across a page) dispatch exactly like a non-branch boundary.
- R7: From the first cycle of the entry sequence until it ends, ret_tag holds the next_tag value present in the dispatching boundary cycle.
- R8: The maskable line is level-sensitive. It is serviceable only when it was low at the end of the previous enabled cycle and is low in the boundary cycle, and only while i_flag=0. A line released before the boundary is not serviced.
- R9: When both lines are serviceable at a boundary, the non-maskable one wins and vec_nmi=1 during the sequence. A maskable line that is still low is taken at a later boundary with vec_nmi=0.
- R10: Dispatch clears the non-maskable request. A line held low afterwards raises no second request until it has gone high and low again.
- R11: While ce=0, no state changes, take_int stays 0 and the entry counter holds its value.
- R12: insn_last pulses during the entry sequence are ignored. No dispatch happens at the end of the sequence itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; one processor cycle per enabled edge |
| irq_n | input | 1 | Maskable request line, active low, level |
| nmi_n | input | 1 | Non-maskable request line, active low, edge |
| i_flag | input | 1 | Interrupt-disable flag from the core |
| insn_last | input | 1 | Current cycle is the final cycle of an instruction |
| br_kind | input | 2 | Kind of the ending instruction: 00 other, 01 branch not taken, 10 taken same page, 11 taken across page |
| next_tag | input | TAG_W | Identifier of the instruction that would run next |
| take_int | output | 1 | Dispatch decided in this boundary cycle |
| vec_nmi | output | 1 | During the sequence: 1 selects the non-maskable vector |
| seq_busy | output | 1 | Entry sequence in progress |
| seq_cnt | output | CNT_W | Entry sequence cycle, 0..6 |
| ret_tag | output | TAG_W | Return tag captured at dispatch |

## Verification
take_int is combinational, so it is due in the very boundary cycle that ends the instruction. seq_cnt=0 appears one enabled edge later, together with vec_nmi and ret_tag, and the count then moves one step per enabled edge, so clock-enable gaps only stretch it. Request lines change at the falling edge. A non-maskable request therefore counts only from the end of its second low cycle, and the scripted instructions place each fall so that the expected boundary is known in advance. Inputs change at the falling edge and outputs are read one nanosecond later. Each expected dispatch carries its absolute cycle number, and the monitor compares that number and then follows the counter through each enabled cycle.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt poll and dispatch sequencer.
// Assumes the core reports the kind of the ending instruction with the code below.
package irq_seq_pkg;

    // Kind of the instruction whose final cycle is being reported.
    typedef enum logic [1:0] {
        BR_NONE       = 2'b00,   // not a branch
        BR_NOT_TAKEN  = 2'b01,   // branch, condition false (2 cycles)
        BR_TAKEN_NEAR = 2'b10,   // branch taken inside the page (3 cycles)
        BR_TAKEN_FAR  = 2'b11    // branch taken across a page (4 cycles)
    } br_kind_e;

endpackage

// File: rtl/irq_line_sampler.sv
// Samples both request lines once per enabled cycle.
// The non-maskable line is edge-detected: a high-to-low step, then a second
// low sample, makes it ready; the request then stays latched until cleared.
// The maskable line is ready when its last two samples are both low.
// Assumes: inputs are already synchronous to clk.
module irq_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic nmi_clr,
    output logic nmi_ready,
    output logic irq_ready
);

    logic nmi_prev;    // line level at the previous enabled edge
    logic nmi_first;   // first low sample after a high one
    logic nmi_pend;    // request latched after the second low sample
    logic irq_prev;    // maskable line level at the previous enabled edge

    // Record line history and latch the non-maskable request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev  <= 1'b1;
            nmi_first <= 1'b0;
            nmi_pend  <= 1'b0;
            irq_prev  <= 1'b1;
        end else if (ce) begin
            nmi_prev  <= nmi_n;
            irq_prev  <= irq_n;
            nmi_first <= nmi_prev & ~nmi_n;
            if (nmi_clr) begin
                nmi_pend <= 1'b0;
            end else if (nmi_first && !nmi_n) begin
                nmi_pend <= 1'b1;
            end
        end
    end

    // Ready when already latched or when this cycle provides the second low sample.
    always_comb begin
        nmi_ready = nmi_pend | (nmi_first & ~nmi_n);
        irq_ready = ~irq_prev & ~irq_n;
    end

endmodule

// File: rtl/irq_boundary_arbiter.sv
// Decides at an instruction boundary whether the entry sequence starts.
// A same-page taken branch makes no poll at its boundary; any other boundary
// polls. The non-maskable request has priority over the maskable one.
// Assumes: insn_last is only meaningful outside the entry sequence.
module irq_boundary_arbiter
    import irq_seq_pkg::*;
(
    input  logic       ce,
    input  logic       insn_last,
    input  logic [1:0] br_kind,
    input  logic       i_flag,
    input  logic       seq_busy,
    input  logic       nmi_ready,
    input  logic       irq_ready,
    output logic       take,
    output logic       pick_nmi
);

    logic no_poll;     // boundary that skips polling
    logic polled;      // an enabled boundary that polls
    logic irq_ok;      // maskable request passes the mask

    // Combine the boundary qualifiers with the request states.
    always_comb begin
        no_poll  = (br_kind_e'(br_kind) == BR_TAKEN_NEAR);
        polled   = ce & insn_last & ~seq_busy & ~no_poll;
        irq_ok   = irq_ready & ~i_flag;
        take     = polled & (nmi_ready | irq_ok);
        pick_nmi = nmi_ready;
    end

endmodule

// File: rtl/irq_entry_counter.sv
// Counts the cycles of the interrupt entry sequence.
// Starts at 0 on the edge that ends the dispatching boundary and returns to
// idle after the last count. Advances only on enabled edges.
module irq_entry_counter #(
    parameter  int ENTRY_CYCLES = 7,
    localparam int CNT_W        = (ENTRY_CYCLES > 1) ? $clog2(ENTRY_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    output logic             busy,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ENTRY_CYCLES - 1);

    // Step through the entry cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (ce) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == LAST_CNT) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_return_latch.sv
// Captures the vector choice and the return tag at the dispatching boundary
// and holds them for the core's push and vector fetch cycles.
module irq_return_latch #(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             capture,
    input  logic             nmi_in,
    input  logic [TAG_W-1:0] tag_in,
    output logic             vec_nmi,
    output logic [TAG_W-1:0] tag_out
);

    // Hold the values of the dispatching boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_nmi <= 1'b0;
            tag_out <= '0;
        end else if (ce && capture) begin
            vec_nmi <= nmi_in;
            tag_out <= tag_in;
        end
    end

endmodule

// File: rtl/irq_dispatch_seq.sv
// Top of the interrupt poll and dispatch sequencer.
// Samples the request lines, polls at each boundary reported by the core
// (except after a same-page taken branch), and runs the entry sequence.
// Assumes: the core stops fetching when take_int is high and drives its
// push and vector cycles from seq_cnt, vec_nmi and ret_tag.
module irq_dispatch_seq #(
    parameter  int TAG_W        = 16,
    parameter  int ENTRY_CYCLES = 7,
    localparam int CNT_W        = (ENTRY_CYCLES > 1) ? $clog2(ENTRY_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             irq_n,
    input  logic             nmi_n,
    input  logic             i_flag,
    input  logic             insn_last,
    input  logic [1:0]       br_kind,
    input  logic [TAG_W-1:0] next_tag,
    output logic             take_int,
    output logic             vec_nmi,
    output logic             seq_busy,
    output logic [CNT_W-1:0] seq_cnt,
    output logic [TAG_W-1:0] ret_tag
);

    logic nmi_ready;
    logic irq_ready;
    logic pick_nmi;
    logic nmi_clr;

    // Clear the non-maskable request when it is the one being dispatched.
    always_comb begin
        nmi_clr = take_int & pick_nmi;
    end

    irq_line_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .nmi_n     (nmi_n),
        .irq_n     (irq_n),
        .nmi_clr   (nmi_clr),
        .nmi_ready (nmi_ready),
        .irq_ready (irq_ready)
    );

    irq_boundary_arbiter u_arbiter (
        .ce        (ce),
        .insn_last (insn_last),
        .br_kind   (br_kind),
        .i_flag    (i_flag),
        .seq_busy  (seq_busy),
        .nmi_ready (nmi_ready),
        .irq_ready (irq_ready),
        .take      (take_int),
        .pick_nmi  (pick_nmi)
    );

    irq_entry_counter #(
        .ENTRY_CYCLES (ENTRY_CYCLES)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .start (take_int),
        .busy  (seq_busy),
        .cnt   (seq_cnt)
    );

    irq_return_latch #(
        .TAG_W (TAG_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .capture (take_int),
        .nmi_in  (pick_nmi),
        .tag_in  (next_tag),
        .vec_nmi (vec_nmi),
        .tag_out (ret_tag)
    );

endmodule

// File: rtl/irq_dispatch_chk.sv
// Property checker for the dispatch sequencer, bound to its top module.
module irq_dispatch_chk #(
    parameter  int TAG_W        = 16,
    parameter  int ENTRY_CYCLES = 7,
    localparam int CNT_W        = (ENTRY_CYCLES > 1) ? $clog2(ENTRY_CYCLES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             insn_last,
    input logic [1:0]       br_kind,
    input logic             i_flag,
    input logic [TAG_W-1:0] next_tag,
    input logic             take_int,
    input logic             pick_nmi,
    input logic             vec_nmi,
    input logic             seq_busy,
    input logic [CNT_W-1:0] seq_cnt,
    input logic [TAG_W-1:0] ret_tag
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ENTRY_CYCLES - 1);

    p_take_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> (insn_last && ce && !seq_busy));

    p_near_branch_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_last && br_kind == 2'b10) |-> !take_int);

    p_seq_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (seq_busy && seq_cnt == '0));

    p_seq_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && ce && seq_cnt != LAST_CNT) |=>
            (seq_busy && seq_cnt == CNT_W'($past(seq_cnt) + 1'b1)));

    p_seq_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && ce && seq_cnt == LAST_CNT) |=> !seq_busy);

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cnt <= LAST_CNT);

    p_tag_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (ret_tag == $past(next_tag)));

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && !pick_nmi) |-> !i_flag);

    p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (vec_nmi == $past(pick_nmi)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(seq_cnt) && $stable(seq_busy) && $stable(ret_tag) && $stable(vec_nmi)));

endmodule

bind irq_dispatch_seq irq_dispatch_chk #(
    .TAG_W        (TAG_W),
    .ENTRY_CYCLES (ENTRY_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .insn_last (insn_last),
    .br_kind   (br_kind),
    .i_flag    (i_flag),
    .next_tag  (next_tag),
    .take_int  (take_int),
    .pick_nmi  (pick_nmi),
    .vec_nmi   (vec_nmi),
    .seq_busy  (seq_busy),
    .seq_cnt   (seq_cnt),
    .ret_tag   (ret_tag)
);

// File: tb/tb_irq_dispatch_seq.sv
// Scoreboard bench: scenario tasks push expected dispatches into a queue,
// a monitor pops them when take_int appears and follows each entry sequence.
module tb_irq_dispatch_seq;

    localparam int TAG_W = 16;
    localparam int ENTRY = 7;
    localparam int CW    = 3;

    logic             clk       = 1'b0;
    logic             rst_n     = 1'b0;
    logic             ce        = 1'b1;
    logic             irq_n     = 1'b1;
    logic             nmi_n     = 1'b1;
    logic             i_flag    = 1'b0;
    logic             insn_last = 1'b0;
    logic [1:0]       br_kind   = 2'b00;
    logic [TAG_W-1:0] next_tag  = '0;
    logic             take_int;
    logic             vec_nmi;
    logic             seq_busy;
    logic [CW-1:0]    seq_cnt;
    logic [TAG_W-1:0] ret_tag;

    // Levels applied at the next falling edge by step().
    logic rst_lvl = 1'b0, ce_lvl = 1'b1, irq_lvl = 1'b1, nmi_lvl = 1'b1, if_lvl = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_dispatch_seq #(.TAG_W(TAG_W), .ENTRY_CYCLES(ENTRY)) dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .irq_n(irq_n), .nmi_n(nmi_n),
        .i_flag(i_flag), .insn_last(insn_last), .br_kind(br_kind),
        .next_tag(next_tag), .take_int(take_int), .vec_nmi(vec_nmi),
        .seq_busy(seq_busy), .seq_cnt(seq_cnt), .ret_tag(ret_tag)
    );

    typedef struct packed {
        int          cyc;
        logic        nmi;
        logic [15:0] tag;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    total = 0;
    int    bad   = 0;
    int    cyc_no = 0;
    string quiet_req = "R1";

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // One processor cycle: inputs change at the falling edge.
    task automatic step(bit last, logic [1:0] kind, logic [15:0] tag);
        @(negedge clk);
        cyc_no++;
        rst_n     = rst_lvl;
        ce        = ce_lvl;
        irq_n     = irq_lvl;
        nmi_n     = nmi_lvl;
        i_flag    = if_lvl;
        insn_last = last;
        br_kind   = kind;
        next_tag  = tag;
    endtask

    task automatic insn(int n, logic [1:0] kind, logic [15:0] tag);
        for (int i = 0; i < n - 1; i++) step(1'b0, 2'b00, '0);
        step(1'b1, kind, tag);
    endtask

    task automatic entry();
        for (int i = 0; i < ENTRY; i++) step(1'b0, 2'b00, '0);
    endtask

    // The next step is expected to dispatch.
    task automatic expect_now(logic nmi, logic [15:0] tag, string req);
        exp_t e;
        e.cyc = cyc_no + 1;
        e.nmi = nmi;
        e.tag = tag;
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic check_quiet(string req);
        check(exp_q.size() == 0, req, "expected dispatch missing", exp_q.size(), 0);
    endtask

    // Monitor: pops expectations on dispatch and follows the entry counter.
    initial begin
        int    exp_cnt;
        bit    trk;
        bit    prev_ce;
        bit    seq_ok;
        exp_t  cur;
        string cur_req;
        trk = 1'b0; prev_ce = 1'b0; exp_cnt = 0; seq_ok = 1'b1;
        cur = '0; cur_req = "";
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                trk = 1'b0;
                prev_ce = 1'b0;
            end else begin
                if (trk) begin
                    if (prev_ce) exp_cnt++;
                    if (exp_cnt == 0) begin
                        check(vec_nmi == cur.nmi, "R9", "vector select", vec_nmi, cur.nmi);
                        check(ret_tag == cur.tag, "R7", "return tag", ret_tag, cur.tag);
                    end
                    if (exp_cnt == ENTRY) begin
                        seq_ok &= !seq_busy;
                        check(seq_ok, "R4", "entry sequence shape", seq_cnt, ENTRY);
                        trk = 1'b0;
                    end else begin
                        seq_ok &= seq_busy && (seq_cnt == CW'(exp_cnt))
                                  && (ret_tag == cur.tag) && (vec_nmi == cur.nmi);
                    end
                end
                if (take_int) begin
                    if (trk || !ce) begin
                        check(1'b0, "R4", "dispatch while busy or disabled", cyc_no, -1);
                    end else if (exp_q.size() == 0) begin
                        check(1'b0, quiet_req, "unexpected dispatch at cycle", cyc_no, -1);
                    end else begin
                        cur     = exp_q.pop_front();
                        cur_req = req_q.pop_front();
                        check(cyc_no == cur.cyc, cur_req, "dispatch cycle", cyc_no, cur.cyc);
                        trk     = 1'b1;
                        exp_cnt = -1;
                        seq_ok  = 1'b1;
                    end
                end
                prev_ce = ce;
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL R4 watchdog: actual=%0d expected=%0d", cyc_no, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Scenarios.
    initial begin
        // R1: reset state
        step(0, 2'b00, '0); step(0, 2'b00, '0); step(0, 2'b00, '0);
        rst_lvl = 1'b1;
        step(0, 2'b00, '0);
        #1;
        check(!seq_busy, "R1", "busy after reset", seq_busy, 0);
        check(seq_cnt == 0, "R1", "count after reset", seq_cnt, 0);
        check(!vec_nmi, "R1", "vector after reset", vec_nmi, 0);
        check(ret_tag == 0, "R1", "tag after reset", ret_tag, 0);
        check(!take_int, "R1", "take after reset", take_int, 0);

        // R3: ordinary boundary, request ready in the final cycle
        quiet_req = "R3";
        step(0, 2'b00, '0);
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        expect_now(1'b1, 16'h0A01, "R3");
        step(1, 2'b00, 16'h0A01);
        entry();
        // R10: line held low raises no second request
        quiet_req = "R10";
        insn(2, 2'b00, 16'h0A02);
        insn(3, 2'b00, 16'h0A03);
        check_quiet("R10");
        nmi_lvl = 1'b1;
        insn(2, 2'b00, 16'h0A04);

        // R5: same-page taken branch defers a non-maskable request
        quiet_req = "R5";
        step(0, 2'b00, '0);
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(1, 2'b10, 16'h0B01);
        step(0, 2'b00, '0);
        expect_now(1'b1, 16'h0B02, "R5");
        step(1, 2'b00, 16'h0B02);
        nmi_lvl = 1'b1;
        entry();
        insn(2, 2'b00, 16'h0B03);

        // R5: same deferral for the maskable line
        step(0, 2'b00, '0);
        irq_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(1, 2'b10, 16'h0C01);
        step(0, 2'b00, '0);
        expect_now(1'b0, 16'h0C02, "R5");
        step(1, 2'b00, 16'h0C02);
        irq_lvl = 1'b1;
        entry();
        insn(2, 2'b00, 16'h0C03);
        check_quiet("R5");

        // R6: not-taken branch dispatches at its own boundary
        quiet_req = "R6";
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        expect_now(1'b1, 16'h0D01, "R6");
        step(1, 2'b01, 16'h0D01);
        nmi_lvl = 1'b1;
        entry();
        // R6: page-crossing branch, maskable line
        step(0, 2'b00, '0);
        irq_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        expect_now(1'b0, 16'h0D02, "R6");
        step(1, 2'b11, 16'h0D02);
        irq_lvl = 1'b1;
        entry();
        // R6: page-crossing branch, non-maskable line
        step(0, 2'b00, '0);
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        expect_now(1'b1, 16'h0D03, "R6");
        step(1, 2'b11, 16'h0D03);
        nmi_lvl = 1'b1;
        entry();
        check_quiet("R6");

        // R2: single low cycle is ignored
        quiet_req = "R2";
        step(0, 2'b00, '0);
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        nmi_lvl = 1'b1;
        step(0, 2'b00, '0);
        insn(2, 2'b00, 16'h0E00);
        insn(2, 2'b00, 16'h0E00);
        check_quiet("R2");
        // R2: low only in the final cycle waits for the next boundary
        step(0, 2'b00, '0);
        nmi_lvl = 1'b0;
        step(1, 2'b00, 16'h0E01);
        step(0, 2'b00, '0);
        expect_now(1'b1, 16'h0E02, "R2");
        step(1, 2'b00, 16'h0E02);
        nmi_lvl = 1'b1;
        entry();

        // R8: masked maskable line
        quiet_req = "R8";
        if_lvl = 1'b1;
        irq_lvl = 1'b0;
        insn(2, 2'b00, 16'h0F00);
        insn(2, 2'b00, 16'h0F00);
        insn(2, 2'b00, 16'h0F00);
        check_quiet("R8");
        if_lvl = 1'b0;
        step(0, 2'b00, '0);
        expect_now(1'b0, 16'h0F01, "R8");
        step(1, 2'b00, 16'h0F01);
        irq_lvl = 1'b1;
        entry();
        // R8: low only in the boundary cycle is not enough
        step(0, 2'b00, '0);
        irq_lvl = 1'b0;
        step(1, 2'b00, 16'h0F02);
        step(0, 2'b00, '0);
        expect_now(1'b0, 16'h0F03, "R8");
        step(1, 2'b00, 16'h0F03);
        irq_lvl = 1'b1;
        entry();
        // R8: released before the boundary
        step(0, 2'b00, '0);
        irq_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        irq_lvl = 1'b1;
        step(1, 2'b00, 16'h0F04);
        insn(2, 2'b00, 16'h0F05);
        check_quiet("R8");

        // R9: both pending, non-maskable first, maskable afterwards
        quiet_req = "R9";
        irq_lvl = 1'b0;
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        expect_now(1'b1, 16'h1001, "R9");
        step(1, 2'b00, 16'h1001);
        nmi_lvl = 1'b1;
        entry();
        step(0, 2'b00, '0);
        expect_now(1'b0, 16'h1002, "R9");
        step(1, 2'b00, 16'h1002);
        irq_lvl = 1'b1;
        entry();

        // R11: disabled cycles do nothing
        quiet_req = "R11";
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        ce_lvl = 1'b0;
        step(1, 2'b00, 16'h1101);
        #1;
        check(!take_int, "R11", "take with clock enable low", take_int, 0);
        ce_lvl = 1'b1;
        expect_now(1'b1, 16'h1102, "R11");
        step(1, 2'b00, 16'h1102);
        nmi_lvl = 1'b1;
        for (int i = 0; i < 10; i++) begin
            ce_lvl = (i % 3 != 1);
            step(0, 2'b00, '0);
        end
        ce_lvl = 1'b1;
        step(0, 2'b00, '0);
        #1;
        check(!seq_busy, "R11", "stretched sequence finished", seq_busy, 0);
        insn(2, 2'b00, 16'h1103);

        // R12: boundary strobes during the sequence are ignored
        quiet_req = "R12";
        irq_lvl = 1'b0;
        step(0, 2'b00, '0);
        expect_now(1'b0, 16'h1201, "R12");
        step(1, 2'b00, 16'h1201);
        for (int i = 0; i < ENTRY; i++) step(1, 2'b00, 16'h12FF);
        step(0, 2'b00, '0);
        expect_now(1'b0, 16'h1202, "R12");
        step(1, 2'b00, 16'h1202);
        irq_lvl = 1'b1;
        entry();
        check_quiet("R12");

        // R1: reset drops a pending request
        quiet_req = "R1";
        nmi_lvl = 1'b0;
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        rst_lvl = 1'b0;
        nmi_lvl = 1'b1;
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        rst_lvl = 1'b1;
        step(0, 2'b00, '0);
        insn(2, 2'b00, 16'h1301);
        insn(2, 2'b00, 16'h1302);
        #1;
        check(!seq_busy, "R1", "busy after second reset", seq_busy, 0);
        check_quiet("R1");

        step(0, 2'b00, '0);
        step(0, 2'b00, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule